// File: doc/BRIEF.md
# Two-Byte Packet Serial Receiver

This block takes an asynchronous serial line from a host and turns it into 16-bit words. Each character on the line has one low start bit, eight data bits sent least significant bit first and one high stop bit. There is no parity and no handshake. The line is sampled sixteen times per bit, and every bit is read at its centre. Characters are grouped in pairs. The first character of a pair becomes the upper half of the word and the second becomes the lower half. Each finished word appears on the output with a one-cycle valid strobe. A consumer can use it to fill a waveform sample table or to decode a command.

The pair of two zero characters is reserved for alignment. It never produces a word, and the character after it always starts a new pair. Two other events also drop a half-built pair and return the framer to the upper-byte state. The first is a character whose stop bit reads low; this also raises a one-cycle error flag. The second is a silence longer than two character times while the framer waits for the lower byte.

Top module: `pkt_uart_rx`

## Requirements
- R1: The idle line is high. A character is a low start bit, eight data bits least significant first, and a high stop bit. The bit period is OVS times the tick divisor, where the divisor is CLK_HZ/(BAUD*OVS). Each bit is sampled at its centre.
- R2: The first character of a pair gives pktWord[15:8] and the second gives pktWord[7:0]. pktValid is high for the cycle after the stop bit of the second character is sampled, and pktWord holds the new word in that cycle.
- R3: A pair of 0x00 followed by 0x00 produces no pktValid, and the next character is taken as the upper byte. A pair with only one zero byte (0x0012, 0x1200) is delivered as normal data.
- R4: A low pulse shorter than half a bit time on an idle line is not taken as a start bit. It produces no output and does not shift the pairing.
- R5: A character whose stop bit reads low sets frameErr high for exactly one cycle. It discards any half-built pair, and the next good character is taken as the upper byte.
- R6: While the lower byte is awaited, an idle gap longer than 20 bit times discards the held upper byte, and the next character is taken as the upper byte.
- R7: An idle gap shorter than 20 bit times between the two characters of a pair still completes the pair.
- R8: After reset, pktValid and frameErr are low and pktWord is 0x0000.
- R9: pktValid is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| pktValid | output | 1 | One-cycle strobe marking a finished word |
| pktWord | output | 16 | Last assembled word, upper byte received first |
| frameErr | output | 1 | One-cycle flag for a character with a low stop bit |

## Verification
Some properties are checked on every cycle. A data character and a framing error never share a cycle. The receiver is idle right after a delivered character. A framing error always sends the framer back to the upper-byte state. The silence counter stays inside its window. The output never carries the reserved all-zero word. The valid strobe never lasts two cycles. The bench scenarios are what show the rest: that bytes land in the correct halves, that the reserved pair and a line glitch leave the pairing intact, and that recovery after a bad stop bit or a long silence starts a fresh pair. Gap lengths on either side of the timeout are among these scenarios.

// File: rtl/pkt_uart_pkg.sv
package pkt_uart_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAITHI
  } rx_state_t;

  typedef enum logic {
    PK_WAIT_HI,
    PK_WAIT_LO
  } pk_state_t;

  typedef struct packed {
    logic loadHigh;
    logic emitWord;
  } pkt_strobe_t;

endpackage

// File: rtl/pkt_uart_bitrx.sv
module pkt_uart_bitrx
  import pkt_uart_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxLine,
  output logic       tick,
  output logic       busy,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       frameErr
);

  localparam int DIV = CLK_HZ / (BAUD * OVS);
  localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int OW  = $clog2(OVS);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);
  localparam logic [OW-1:0] HALF_LAST = OW'(OVS / 2 - 1);

  logic [DW-1:0] divCnt;
  logic [OW-1:0] ovsCnt;
  logic [2:0]    bitIdx;
  logic [7:0]    shiftReg;
  logic          rxMeta, rxSync;
  rx_state_t     state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      ovsCnt    <= '0;
      bitIdx    <= '0;
      shiftReg  <= '0;
      byteValid <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      frameErr  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!rxSync) begin
            state  <= RX_START;
            ovsCnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (ovsCnt == HALF_LAST) begin
              ovsCnt <= '0;
              bitIdx <= '0;
              state  <= rxSync ? RX_IDLE : RX_DATA;
            end else begin
              ovsCnt <= ovsCnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (ovsCnt == OVS_LAST) begin
              ovsCnt   <= '0;
              shiftReg <= {rxSync, shiftReg[7:1]};
              if (bitIdx == 3'd7) state <= RX_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end else begin
              ovsCnt <= ovsCnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (ovsCnt == OVS_LAST) begin
              ovsCnt <= '0;
              if (rxSync) begin
                byteValid <= 1'b1;
                state     <= RX_IDLE;
              end else begin
                frameErr <= 1'b1;
                state    <= RX_WAITHI;
              end
            end else begin
              ovsCnt <= ovsCnt + 1'b1;
            end
          end
        end
        RX_WAITHI: begin
          if (rxSync) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy     = (state != RX_IDLE);
  assign byteData = shiftReg;

  // R1: a character ends either good or bad, never both
  a_r1_valid_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(byteValid && frameErr));

  // R1: after a delivered character the receiver is back at idle
  a_r1_idle_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |=> !busy);

endmodule

// File: rtl/pkt_uart_ctrl.sv
module pkt_uart_ctrl
  import pkt_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        busy,
  input  logic        byteValid,
  input  logic        byteIsZero,
  input  logic        frameErr,
  output pkt_strobe_t strobe
);

  localparam int TO_TICKS = 20 * OVS;
  localparam int TW = $clog2(TO_TICKS + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TO_TICKS - 1);

  pk_state_t     state;
  logic          hiZero;
  logic [TW-1:0] toCnt;

  always_comb begin
    strobe.loadHigh = byteValid && (state == PK_WAIT_HI);
    strobe.emitWord = byteValid && (state == PK_WAIT_LO) && !(hiZero && byteIsZero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PK_WAIT_HI;
      hiZero <= 1'b0;
      toCnt  <= '0;
    end else if (frameErr) begin
      state <= PK_WAIT_HI;
      toCnt <= '0;
    end else if (byteValid) begin
      toCnt <= '0;
      if (state == PK_WAIT_HI) begin
        state  <= PK_WAIT_LO;
        hiZero <= byteIsZero;
      end else begin
        state <= PK_WAIT_HI;
      end
    end else if (state == PK_WAIT_LO) begin
      if (busy) begin
        toCnt <= '0;
      end else if (tick) begin
        if (toCnt == TO_LAST) begin
          state <= PK_WAIT_HI;
          toCnt <= '0;
        end else begin
          toCnt <= toCnt + 1'b1;
        end
      end
    end
  end

  // R5: a bad stop bit always leaves the framer expecting an upper byte
  a_r5_err_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |=> (state == PK_WAIT_HI));

  // R6: silence counter stays inside the two-character window
  a_r6_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    toCnt <= TO_LAST);

endmodule

// File: rtl/pkt_uart_dp.sv
module pkt_uart_dp
  import pkt_uart_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pkt_strobe_t strobe,
  input  logic [7:0]  byteData,
  output logic        pktValid,
  output logic [15:0] pktWord
);

  logic [7:0] hiReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiReg    <= '0;
      pktWord  <= '0;
      pktValid <= 1'b0;
    end else begin
      pktValid <= strobe.emitWord;
      if (strobe.loadHigh) hiReg <= byteData;
      if (strobe.emitWord) pktWord <= {hiReg, byteData};
    end
  end

  // R3: the reserved alignment pair never reaches the output
  a_r3_sync_never_out: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |-> (pktWord != 16'h0000));

  // R9: the valid strobe is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |=> !pktValid);

endmodule

// File: rtl/pkt_uart_rx.sv
module pkt_uart_rx
  import pkt_uart_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int OVS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxLine,
  output logic        pktValid,
  output logic [15:0] pktWord,
  output logic        frameErr
);

  logic        tick, busy, byteValid;
  logic [7:0]  byteData;
  pkt_strobe_t strobe;

  pkt_uart_bitrx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) u_bitrx (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .tick(tick), .busy(busy),
    .byteValid(byteValid), .byteData(byteData), .frameErr(frameErr)
  );

  pkt_uart_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .byteValid(byteValid),
    .byteIsZero(byteData == 8'h00), .frameErr(frameErr), .strobe(strobe)
  );

  pkt_uart_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .byteData(byteData),
    .pktValid(pktValid), .pktWord(pktWord)
  );

endmodule

// File: tb/pkt_uart_rx_tb.sv
`timescale 1ns/1ps
module pkt_uart_rx_tb;

  localparam int CLK_HZ = 1_600_000;
  localparam int BAUD   = 25_000;
  localparam int OVS    = 16;
  localparam int BITC   = (CLK_HZ / (BAUD * OVS)) * OVS;
  localparam int NVEC   = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1234, 16'hA55A, 16'hFFFF, 16'h0012,
    16'h1200, 16'h0180, 16'h7E81, 16'hC3D2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxLine = 1'b1;
  logic pktValid, frameErr;
  logic [15:0] pktWord;

  int checks = 0, fails = 0;
  int pktCnt = 0, errCnt = 0, pulseBad = 0;
  logic [15:0] lastWord = '0;
  logic prevValid = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pkt_uart_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine),
    .pktValid(pktValid), .pktWord(pktWord), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    if (pktValid) begin
      pktCnt++;
      lastWord = pktWord;
    end
    if (pktValid && prevValid) pulseBad++;
    prevValid = pktValid;
    if (frameErr) errCnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleBits(input int n);
    rxLine = 1'b1;
    repeat (n * BITC) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit stopHigh);
    rxLine = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxLine = stopHigh;
    repeat (BITC) @(negedge clk);
    rxLine = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(pktValid == 1'b0, "R8 pktValid", int'(pktValid), 0);
    chk(frameErr == 1'b0, "R8 frameErr", int'(frameErr), 0);
    chk(pktWord == 16'h0000, "R8 pktWord", int'(pktWord), 0);
    rst_n = 1'b1;
    idleBits(2);

    // R1 R2: vector table walk
    for (int v = 0; v < NVEC; v++) begin
      base = pktCnt;
      sendByte(VEC[v][15:8], 1'b1);
      sendByte(VEC[v][7:0], 1'b1);
      idleBits(1);
      chk(pktCnt == base + 1, "R2 count", pktCnt - base, 1);
      chk(lastWord == VEC[v], "R1 R2 word", int'(lastWord), int'(VEC[v]));
    end

    // R3: alignment pair silent, next byte is upper
    base = pktCnt;
    sendByte(8'h00, 1'b1);
    sendByte(8'h00, 1'b1);
    idleBits(1);
    chk(pktCnt == base, "R3 sync silent", pktCnt - base, 0);
    sendByte(8'hAB, 1'b1);
    sendByte(8'hCD, 1'b1);
    idleBits(1);
    chk(pktCnt == base + 1 && lastWord == 16'hABCD, "R3 after sync", int'(lastWord), 16'hABCD);

    // R4: short glitch ignored
    base = pktCnt;
    rxLine = 1'b0;
    repeat (BITC / 4) @(negedge clk);
    idleBits(2);
    chk(pktCnt == base && errCnt == 0, "R4 glitch", pktCnt - base, 0);
    sendByte(8'h5E, 1'b1);
    sendByte(8'h6F, 1'b1);
    idleBits(1);
    chk(pktCnt == base + 1 && lastWord == 16'h5E6F, "R4 pairing kept", int'(lastWord), 16'h5E6F);

    // R5: bad stop bit
    base = pktCnt;
    sendByte(8'h44, 1'b1);
    sendByte(8'h55, 1'b0);
    idleBits(2);
    chk(errCnt == 1, "R5 frameErr pulses", errCnt, 1);
    chk(pktCnt == base, "R5 pair dropped", pktCnt - base, 0);
    sendByte(8'h66, 1'b1);
    sendByte(8'h77, 1'b1);
    idleBits(1);
    chk(pktCnt == base + 1 && lastWord == 16'h6677, "R5 restart", int'(lastWord), 16'h6677);

    // R6: long silence drops upper byte
    base = pktCnt;
    sendByte(8'h88, 1'b1);
    idleBits(25);
    sendByte(8'h99, 1'b1);
    sendByte(8'hAA, 1'b1);
    idleBits(1);
    chk(pktCnt == base + 1 && lastWord == 16'h99AA, "R6 timeout", int'(lastWord), 16'h99AA);

    // R7: gap under the limit keeps the pair
    base = pktCnt;
    sendByte(8'h21, 1'b1);
    idleBits(12);
    sendByte(8'h43, 1'b1);
    idleBits(1);
    chk(pktCnt == base + 1 && lastWord == 16'h2143, "R7 short gap", int'(lastWord), 16'h2143);

    // R9: every valid pulse was one cycle
    chk(pulseBad == 0, "R9 pulse width", pulseBad, 0);
    finishRun();
  end

endmodule